// File: doc/BRIEF.md
# Clocked Bus Read Master with Wait States

This block is the processor-side engine for read transfers on a clocked memory bus. The core hands it an address with a one-cycle request. The block places the address on the bus and raises its memory-request and read strobes together. It then holds them while the addressed slave stretches the transfer with its wait line. It takes the data word only in the window where both strobes are active and wait is clear. The word goes back to the core together with a done pulse, and the strobes are released in the same step.

The block works on both edges of the bus clock. A transfer is launched on a rising edge. The wait line is sampled on every falling edge, and the transfer is completed on a falling edge. Because of this, the next transfer can be launched on the very next rising edge. Each falling edge that finds wait high adds one full clock period to the transfer. A request that arrives while a transfer is in flight is held in a single slot and launched as soon as the bus is free. While that slot is occupied, further requests are dropped, so the core issues at most one request ahead.

Top module: `sbr_read_master`

## Requirements
- R1: The strobes bus_mreq and bus_rd can change from inactive to active only across a rising clock edge; a transfer never begins on a falling edge.
- R2: The strobes can change from active to inactive only across a falling clock edge; the last step of a transfer is always on a falling edge.
- R3: On a rising edge with no transfer active and a request present (held or new), bus_addr takes that request's address, and bus_mreq and bus_rd (both active-high) become 1 together.
- R4: While bus_wait is 1 at a falling edge, the strobes stay 1 and bus_addr stays unchanged through the next falling edge; each such edge lengthens the transfer by one clock period.
- R5: At the first falling edge with strobes active and bus_wait 0, rdata takes bus_data and done becomes 1 for one clock period; no capture happens at an edge where bus_wait is 1.
- R6: When a transfer completes on a falling edge, a request presented for the next rising edge is launched on that edge, with no idle cycle between transfers.
- R7: A request seen on a rising edge while a transfer is active is held with its address and launched on the first rising edge after that transfer completes.
- R8: busy is 1 from the rising edge that accepts a request until the falling edge that completes the last accepted transfer, including while a request is held.
- R9: With rst (synchronous, active-high) applied over at least one full clock, bus_mreq, bus_rd, busy and done are 0, and bus_addr and rdata are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle read request from the core, sampled on rising edges |
| addr | input | AW | Address of the requested word, sampled with req |
| busy | output | 1 | A transfer is active or a request is held |
| done | output | 1 | One clock period high per completed transfer |
| rdata | output | DW | Word captured by the most recent transfer |
| bus_addr | output | AW | Address driven to the memory bus |
| bus_mreq | output | 1 | Memory-request strobe, active-high |
| bus_rd | output | 1 | Read strobe, active-high |
| bus_wait | input | 1 | Wait line from the slave, high stretches the transfer |
| bus_data | input | DW | Read data from the slave |

## Verification
The bench builds the block with a 16-bit address and a 32-bit data word. This is wide enough to give each address a distinct word, so a capture from the wrong transfer or from the wrong edge shows up as a data mismatch. The wait depth is not a parameter. The bench's behavioural memory picks 0 to 7 wait states per transfer, and directed runs force 0, 2, 3, 4 and 7. This reaches the zero-wait half-cycle transfer, long stretches, back-to-back launches and a request held behind a stretched transfer. While wait is high, the memory drives the complement of the correct word, so a capture inside a wait state cannot go unnoticed.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // Decision taken on each falling edge for the active transfer.
  typedef enum logic [1:0] {
    CAP_IDLE    = 2'd0,
    CAP_STRETCH = 2'd1,
    CAP_TAKE    = 2'd2
  } cap_e;

endpackage

// File: rtl/sbr_launch.sv
module sbr_launch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          active,
  output logic          start_tgl,
  output logic [AW-1:0] bus_addr,
  output logic          held_v
);

  logic [AW-1:0] held_addr;
  logic          launch;
  logic [AW-1:0] launch_addr;

  // A held request always goes before a fresh one.
  always_comb begin
    launch      = !active && (held_v || req);
    launch_addr = held_v ? held_addr : addr;
  end

  // Rising-edge steps: launch a transfer and park a request that arrives
  // while the bus is occupied.
  always_ff @(posedge clk) begin
    if (rst) begin
      start_tgl <= 1'b0;
      bus_addr  <= '0;
      held_v    <= 1'b0;
      held_addr <= '0;
    end else begin
      if (launch) begin
        start_tgl <= ~start_tgl;
        bus_addr  <= launch_addr;
      end
      if (launch && held_v) begin
        held_v <= req;
        if (req) held_addr <= addr;
      end else if (active && req && !held_v) begin
        held_v    <= 1'b1;
        held_addr <= addr;
      end
    end
  end

endmodule

// File: rtl/sbr_capture.sv
module sbr_capture
  import sbr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          bus_wait,
  input  logic [DW-1:0] bus_data,
  output logic          end_tgl,
  output logic          done,
  output logic [DW-1:0] rdata
);

  cap_e cap;

  always_comb begin
    if (!active)      cap = CAP_IDLE;
    else if (bus_wait) cap = CAP_STRETCH;
    else               cap = CAP_TAKE;
  end

  // Falling-edge steps: sample wait, take the word and close the transfer.
  always_ff @(negedge clk) begin
    if (rst) begin
      end_tgl <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= (cap == CAP_TAKE);
      if (cap == CAP_TAKE) begin
        end_tgl <= ~end_tgl;
        rdata   <= bus_data;
      end
    end
  end

endmodule

// File: rtl/sbr_read_master.sv
module sbr_read_master #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_mreq,
  output logic          bus_rd,
  input  logic          bus_wait,
  input  logic [DW-1:0] bus_data
);

  logic start_tgl;
  logic end_tgl;
  logic held_v;
  logic active;

  // A transfer is in flight while the rising-edge launch count is one
  // ahead of the falling-edge completion count.
  assign active   = start_tgl ^ end_tgl;
  assign bus_mreq = active;
  assign bus_rd   = active;
  assign busy     = active | held_v;

  sbr_launch #(.AW(AW)) u_launch (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .addr      (addr),
    .active    (active),
    .start_tgl (start_tgl),
    .bus_addr  (bus_addr),
    .held_v    (held_v)
  );

  sbr_capture #(.DW(DW)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .bus_wait (bus_wait),
    .bus_data (bus_data),
    .end_tgl  (end_tgl),
    .done     (done),
    .rdata    (rdata)
  );

endmodule

// File: rtl/sbr_read_master_chk.sv
module sbr_read_master_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic [AW-1:0] bus_addr,
  input logic          bus_mreq,
  input logic          bus_rd,
  input logic          bus_wait,
  input logic [DW-1:0] bus_data
);

  logic mreq_high_phase;
  logic mreq_low_phase;

  always_ff @(negedge clk) begin
    if (rst) mreq_high_phase <= 1'b0;
    else     mreq_high_phase <= bus_mreq;
  end

  always_ff @(posedge clk) begin
    if (rst) mreq_low_phase <= 1'b0;
    else     mreq_low_phase <= bus_mreq;
  end

  a_r1_start_on_rise: assert property (@(posedge clk) disable iff (rst)
    !mreq_high_phase |-> !bus_mreq);

  a_r2_end_on_fall: assert property (@(negedge clk) disable iff (rst)
    mreq_low_phase |-> bus_mreq);

  a_r4_hold_in_wait: assert property (@(negedge clk) disable iff (rst)
    (bus_mreq && bus_wait) |=> (bus_mreq && bus_rd && $stable(bus_addr)));

  a_r5_capture_window: assert property (@(negedge clk) disable iff (rst)
    done |-> $past(bus_mreq && bus_rd && !bus_wait));

  a_r5_capture_data: assert property (@(negedge clk) disable iff (rst)
    done |-> (rdata == $past(bus_data)));

  a_r9_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_mreq && !busy && !done && bus_addr == '0));

endmodule

bind sbr_read_master sbr_read_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .rdata    (rdata),
  .bus_addr (bus_addr),
  .bus_mreq (bus_mreq),
  .bus_rd   (bus_rd),
  .bus_wait (bus_wait),
  .bus_data (bus_data)
);

// File: tb/sbr_read_master_bench.sv
module sbr_read_master_bench;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          bus_wait = 1'b0;
  logic [DW-1:0] bus_data = '0;
  logic          busy, done, bus_mreq, bus_rd;
  logic [DW-1:0] rdata;
  logic [AW-1:0] bus_addr;

  always #4 clk = ~clk;

  sbr_read_master #(.AW(AW), .DW(DW)) u_sbr_read_master (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .busy(busy), .done(done),
    .rdata(rdata), .bus_addr(bus_addr), .bus_mreq(bus_mreq), .bus_rd(bus_rd),
    .bus_wait(bus_wait), .bus_data(bus_data)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;
  string tag = "R9";

  // Reference model state
  bit            m_active = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_rdata = '0;
  bit            m_done = 1'b0;
  logic [AW-1:0] held_q[$];

  // Behavioural memory state
  bit in_xfer = 1'b0;
  int wcnt = 0;
  int force_wait = -1;

  function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
    return DW'(a) * 32'h0001_9E37 ^ 32'hA5A5_0F0F;
  endfunction

  task automatic check(string r, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: actual=%0h expected=%0h", r, tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string edge_tag);
    check(edge_tag, "bus_mreq", 64'(bus_mreq), 64'(m_active));
    check("R4", "bus_rd", 64'(bus_rd), 64'(m_active));
    check("R3", "bus_addr", 64'(bus_addr), 64'(m_addr));
    check("R5", "done", 64'(done), 64'(m_done));
    check("R5", "rdata", 64'(rdata), 64'(m_rdata));
    check("R8", "busy", 64'(busy), 64'(m_active || held_q.size() > 0));
  endtask

  task automatic model_rise();
    if (rst) begin
      held_q.delete();
      m_active = 1'b0;
      m_addr = '0;
      return;
    end
    if (req && (held_q.size() == 0 || !m_active)) held_q.push_back(addr);
    if (!m_active && held_q.size() > 0) begin
      m_addr = held_q.pop_front();
      m_active = 1'b1;
    end
  endtask

  task automatic model_fall();
    if (rst) begin
      m_active = 1'b0;
      m_done = 1'b0;
      m_rdata = '0;
      return;
    end
    if (m_active && !bus_wait) begin
      m_rdata = word_of(m_addr);
      m_done = 1'b1;
      m_active = 1'b0;
    end else begin
      m_done = 1'b0;
    end
  endtask

  task automatic drive_data();
    if (bus_mreq && bus_rd)
      bus_data = bus_wait ? ~word_of(bus_addr) : word_of(bus_addr);
    else
      bus_data = '0;
  endtask

  task automatic mem_after_rise();
    if (rst) begin
      in_xfer = 1'b0;
      bus_wait = 1'b0;
    end else if (bus_mreq && !in_xfer) begin
      in_xfer = 1'b1;
      wcnt = (force_wait >= 0) ? force_wait : int'($urandom_range(0, 7));
      bus_wait = (wcnt > 0);
    end
    drive_data();
  endtask

  task automatic mem_after_fall();
    if (in_xfer) begin
      if (bus_wait) begin
        wcnt--;
        bus_wait = (wcnt > 0);
      end else begin
        in_xfer = 1'b0;
      end
    end
    drive_data();
  endtask

  // One bus clock; returns 3 ns after the falling edge.
  task automatic step();
    @(posedge clk);
    model_rise();
    #1 mem_after_rise();
    #2 if (!rst) compare_all("R1");
    @(negedge clk);
    model_fall();
    #1 mem_after_fall();
    #2 if (!rst) compare_all("R2");
  endtask

  task automatic issue(logic [AW-1:0] a);
    req = 1'b1;
    addr = a;
    step();
    req = 1'b0;
  endtask

  task automatic drain();
    for (int g = 0; g < 100 && (m_active || held_q.size() > 0); g++) step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R9: reset state seen at the ports
    check("R9", "bus_mreq", 64'(bus_mreq), 64'(0));
    check("R9", "bus_rd", 64'(bus_rd), 64'(0));
    check("R9", "bus_addr", 64'(bus_addr), 64'(0));
    check("R9", "busy", 64'(busy), 64'(0));
    check("R9", "done", 64'(done), 64'(0));
    check("R9", "rdata", 64'(rdata), 64'(0));
    step();

    // R3 and R5: single reads with fixed wait counts
    tag = "R3";
    force_wait = 0; issue(16'h0010); drain();
    check("R5", "rdata zero-wait", 64'(rdata), 64'(word_of(16'h0010)));
    force_wait = 3; issue(16'h0123); drain();
    check("R5", "rdata 3 waits", 64'(rdata), 64'(word_of(16'h0123)));
    force_wait = 7; issue(16'hFFFF); drain();
    check("R5", "rdata 7 waits", 64'(rdata), 64'(word_of(16'hFFFF)));

    // R4: two wait states keep the strobes up for two falling edges
    tag = "R4";
    force_wait = 2;
    issue(16'h0444);
    check("R4", "strobe after 1st wait edge", 64'(bus_mreq), 64'(1));
    check("R4", "done during wait", 64'(done), 64'(0));
    step();
    check("R4", "strobe after 2nd wait edge", 64'(bus_mreq), 64'(1));
    check("R4", "address held", 64'(bus_addr), 64'(16'h0444));
    step();
    check("R5", "done after wait clears", 64'(done), 64'(1));
    check("R5", "captured word", 64'(rdata), 64'(word_of(16'h0444)));
    check("R2", "strobe released", 64'(bus_mreq), 64'(0));

    // R6: back-to-back zero-wait transfers
    tag = "R6";
    force_wait = 0;
    for (int i = 0; i < 6; i++) begin
      req = 1'b1;
      addr = AW'(16'h0200 + i);
      step();
      check("R6", "done each cycle", 64'(done), 64'(1));
      check("R6", "word each cycle", 64'(rdata), 64'(word_of(AW'(16'h0200 + i))));
    end
    req = 1'b0;
    drain();

    // R7 and R8: request held behind a stretched transfer
    tag = "R7";
    force_wait = 4;
    issue(16'h0300);
    issue(16'h0301);
    check("R8", "busy with held request", 64'(busy), 64'(1));
    check("R7", "first address still driven", 64'(bus_addr), 64'(16'h0300));
    drain();
    check("R7", "held request served", 64'(rdata), 64'(word_of(16'h0301)));
    check("R7", "held address driven", 64'(bus_addr), 64'(16'h0301));
    check("R8", "busy after drain", 64'(busy), 64'(0));
    step();

    // Random traffic, random wait states
    tag = "R5";
    force_wait = -1;
    for (int n = 0; n < 400; n++) begin
      req = ($urandom_range(0, 2) == 0);
      addr = AW'($urandom);
      step();
    end
    req = 1'b0;
    drain();
    step();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (%s): actual=hung expected=finished", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule